// File: doc/BRIEF.md
# Integer Compare Unit with Condition-Register Field Update

This block compares two 32-bit integers and records the outcome in a 32-bit condition register made of eight 4-bit fields. The first operand is always register A. The second operand is either register B or a 16-bit immediate. The immediate is widened to 32 bits by sign extension in signed mode and by zero extension in unsigned mode. The same signed/unsigned select also picks the kind of comparison: two's-complement order or plain magnitude order.

Each accepted compare writes one field. The field holds three mutually exclusive ordering flags (less, greater, equal) and a copy of the incoming summary-overflow flag. A 3-bit index picks the target field, and index 0 is the default target. All other fields keep their values. The updated register is visible on the output one clock edge after the valid strobe.

The block is meant to sit in an integer pipeline next to the register file. Parameters let an integration choose the operand width, the immediate width, the number of fields and one of two comparator structures.

Top module: `intcmp_crf`

## Requirements
- R1: An active-low reset clears every bit of `cr_o` to zero, and `cr_o` stays zero until the first accepted compare.
- R2: With `signed_i`=1 the operands are ordered as two's-complement numbers. With `signed_i`=0 they are ordered as unsigned magnitudes. For example, 0xFFFF_FFFF against 1 gives less in signed mode and greater in unsigned mode.
- R3: With `use_imm_i`=1 and `signed_i`=0, the second operand is `imm_i` zero-extended to 32 bits.
- R4: With `use_imm_i`=1 and `signed_i`=1, the second operand is `imm_i` sign-extended from bit 15 to 32 bits.
- R5: With `use_imm_i`=0, the second operand is `opb_i`, and `imm_i` has no effect on the result.
- R6: A written field uses bit 3 for less, bit 2 for greater, bit 1 for equal and bit 0 for summary overflow. Exactly one of bits 3..1 is set after a write.
- R7: Bit 0 of the written field equals the `so_i` value presented with the compare.
- R8: Field k occupies `cr_o` bits [31-4k : 28-4k]: field 0 is bits 31:28 and field 7 is bits 3:0. Index 0 selects field 0. A write leaves every other field unchanged.
- R9: A compare presented with `valid_i`=1 shows on `cr_o` right after the next rising clock edge and not before. While `valid_i`=0, `cr_o` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Accept the compare presented this cycle |
| opa_i | input | 32 | First operand (register A) |
| opb_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate operand before extension |
| use_imm_i | input | 1 | 1: compare against the immediate, 0: against `opb_i` |
| signed_i | input | 1 | 1: signed compare and sign extension, 0: unsigned compare and zero extension |
| field_i | input | 3 | Index of the condition field to write |
| so_i | input | 1 | Current summary-overflow flag to copy into the field |
| cr_o | output | 32 | Condition register after the last update |

## Verification
Every result of this block is due one clock edge after the strobe. The operand select, the immediate extension and the comparison are all combinational in front of the single field register. The bench therefore drives each compare on a falling edge and first confirms that `cr_o` has not yet moved in that half-cycle. It then samples the whole register on the following falling edge, after exactly one rising edge. The idle-hold and reset checks use the same spacing: inputs change on a falling edge, and the comparison is made after the next rising edge has passed.

// File: rtl/intcmp_pkg.sv
package intcmp_pkg;

   // Layout of one condition field, most significant bit first.
   localparam int unsigned CRF_W     = 4;
   localparam int unsigned CRF_LT    = 3;
   localparam int unsigned CRF_GT    = 2;
   localparam int unsigned CRF_EQ    = 1;
   localparam int unsigned CRF_SO    = 0;

   // Comparator structure choices.
   localparam int unsigned MAG_RELATIONAL = 0;
   localparam int unsigned MAG_SUBTRACT   = 1;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } crf_nib_t;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
   } order_t;

endpackage

// File: rtl/intcmp_opsel.sv
module intcmp_opsel #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 16
) (
   input  logic [DATA_W-1:0] reg_b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   input  logic              signed_i,
   output logic [DATA_W-1:0] opnd_o
);

   localparam int unsigned EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_wide;

   generate
      if (IMM_W > DATA_W) begin : g_bad_width
         $error("intcmp_opsel: IMM_W must not exceed DATA_W");
      end
      if (IMM_W < 1) begin : g_bad_imm
         $error("intcmp_opsel: IMM_W must be at least 1");
      end

      if (EXT_W > 0) begin : g_extend
         logic fill_bit;
         // Sign bit replicated only in signed mode; zeros otherwise.
         assign fill_bit = signed_i & imm_i[IMM_W-1];
         assign imm_wide = {{EXT_W{fill_bit}}, imm_i};
      end else begin : g_same_width
         assign imm_wide = imm_i[DATA_W-1:0];
      end
   endgenerate

   assign opnd_o = use_imm_i ? imm_wide : reg_b_i;

endmodule

// File: rtl/intcmp_mag.sv
module intcmp_mag
   import intcmp_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MAG_STYLE = MAG_SUBTRACT
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              signed_i,
   output order_t            ord_o
);

   localparam int unsigned MSB = DATA_W - 1;

   // Flipping the top bit in signed mode maps two's-complement order onto
   // unsigned order, so a single unsigned comparator serves both modes.
   logic [DATA_W-1:0] a_bias;
   logic [DATA_W-1:0] b_bias;
   logic              is_lt;
   logic              is_eq;

   assign a_bias = {a_i[MSB] ^ signed_i, a_i[MSB-1:0]};
   assign b_bias = {b_i[MSB] ^ signed_i, b_i[MSB-1:0]};

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("intcmp_mag: DATA_W must be at least 2");
      end
      if (MAG_STYLE != MAG_RELATIONAL && MAG_STYLE != MAG_SUBTRACT) begin : g_bad_style
         $error("intcmp_mag: unknown MAG_STYLE");
      end

      if (MAG_STYLE == MAG_SUBTRACT) begin : g_subtract
         logic [DATA_W:0] diff;
         assign diff  = {1'b0, a_bias} - {1'b0, b_bias};
         assign is_lt = diff[DATA_W];
         assign is_eq = ~|diff[DATA_W-1:0];
      end else begin : g_relational
         assign is_lt = (a_bias < b_bias);
         assign is_eq = (a_bias == b_bias);
      end
   endgenerate

   assign ord_o.lt = is_lt;
   assign ord_o.eq = is_eq;
   assign ord_o.gt = ~is_lt & ~is_eq;

endmodule

// File: rtl/intcmp_crfile.sv
module intcmp_crfile
   import intcmp_pkg::*;
#(
   parameter int unsigned NUM_FIELDS = 8,
   parameter int unsigned FIELD_W    = CRF_W,
   localparam int unsigned SEL_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
   localparam int unsigned CR_W      = NUM_FIELDS * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [FIELD_W-1:0] nib_i,
   output logic [CR_W-1:0]    cr_o
);

   generate
      if (NUM_FIELDS < 1) begin : g_bad_count
         $error("intcmp_crfile: NUM_FIELDS must be at least 1");
      end
      if (FIELD_W < 1) begin : g_bad_field
         $error("intcmp_crfile: FIELD_W must be at least 1");
      end

      // Field 0 sits at the top of the register, the last field at the bottom.
      for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
         localparam int unsigned HI = CR_W - 1 - k * FIELD_W;
         logic [FIELD_W-1:0] fld_q;
         logic               hit;

         assign hit = wr_en_i && (sel_i == SEL_W'(k));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fld_q <= '0;
            end else if (hit) begin
               fld_q <= nib_i;
            end
         end

         assign cr_o[HI -: FIELD_W] = fld_q;

         // R8: a write aimed elsewhere leaves this field alone.
         p_other_field_hold_r8: assert property (
            @(posedge clk) disable iff (!rst_n)
            (wr_en_i && (sel_i != SEL_W'(k))) |=> $stable(cr_o[HI -: FIELD_W]))
            else $error("field %0d changed on a foreign write", k);

         // R8: a write aimed here lands the presented nibble.
         p_target_field_load_r8: assert property (
            @(posedge clk) disable iff (!rst_n)
            (wr_en_i && (sel_i == SEL_W'(k))) |=> (cr_o[HI -: FIELD_W] == $past(nib_i)))
            else $error("field %0d missed its write", k);
      end
   endgenerate

   // R9: with no strobe the whole register is frozen.
   p_idle_hold_r9: assert property (
      @(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(cr_o))
      else $error("condition register moved without a strobe");

endmodule

// File: rtl/intcmp_crf.sv
module intcmp_crf
   import intcmp_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned IMM_W      = 16,
   parameter int unsigned NUM_FIELDS = 8,
   parameter int unsigned MAG_STYLE  = MAG_SUBTRACT,
   localparam int unsigned SEL_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
   localparam int unsigned CR_W      = NUM_FIELDS * CRF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   input  logic              signed_i,
   input  logic [SEL_W-1:0]  field_i,
   input  logic              so_i,
   output logic [CR_W-1:0]   cr_o
);

   logic [DATA_W-1:0] opnd_b;
   order_t            ord;
   crf_nib_t          nib;

   intcmp_opsel #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W)
   ) u_opsel (
      .reg_b_i   (opb_i),
      .imm_i     (imm_i),
      .use_imm_i (use_imm_i),
      .signed_i  (signed_i),
      .opnd_o    (opnd_b)
   );

   intcmp_mag #(
      .DATA_W    (DATA_W),
      .MAG_STYLE (MAG_STYLE)
   ) u_mag (
      .a_i      (opa_i),
      .b_i      (opnd_b),
      .signed_i (signed_i),
      .ord_o    (ord)
   );

   assign nib.lt = ord.lt;
   assign nib.gt = ord.gt;
   assign nib.eq = ord.eq;
   assign nib.so = so_i;

   intcmp_crfile #(
      .NUM_FIELDS (NUM_FIELDS),
      .FIELD_W    (CRF_W)
   ) u_crfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (valid_i),
      .sel_i   (field_i),
      .nib_i   (nib),
      .cr_o    (cr_o)
   );

   function automatic logic [CRF_W-1:0] pick_field(input logic [CR_W-1:0] cr,
                                                   input logic [SEL_W-1:0] idx);
      return cr[CR_W - 1 - int'(idx) * CRF_W -: CRF_W];
   endfunction

   // R6: exactly one ordering flag in the field just written.
   p_one_order_flag_r6: assert property (
      @(posedge clk) disable iff (!rst_n)
      valid_i |=> ($countones(pick_field(cr_o, $past(field_i)) >> 1) == 1))
      else $error("written field has not exactly one ordering flag");

   // R7: summary-overflow bit copied from the input.
   p_so_copy_r7: assert property (
      @(posedge clk) disable iff (!rst_n)
      valid_i |=> (pick_field(cr_o, $past(field_i))[CRF_SO] == $past(so_i)))
      else $error("summary-overflow bit not copied");

   // R5: equal register operands always report equal.
   p_reg_equal_r5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (valid_i && !use_imm_i && (opa_i == opb_i)) |=>
         pick_field(cr_o, $past(field_i))[CRF_EQ])
      else $error("equal register operands not reported equal");

   // R2: the top-bit-only difference flips order between modes.
   p_mode_order_r2: assert property (
      @(posedge clk) disable iff (!rst_n)
      (valid_i && !use_imm_i && (opa_i[DATA_W-1] && !opb_i[DATA_W-1])) |=>
         (pick_field(cr_o, $past(field_i))[CRF_LT] == $past(signed_i)))
      else $error("sign-dependent order wrong");

endmodule

// File: tb/intcmp_crf_bench.sv
module intcmp_crf_bench;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] imm;
      logic        use_imm;
      logic        sgn;
      logic [2:0]  fld;
      logic        so;
      logic [3:0]  expn;   // {LT,GT,EQ,SO}
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      // R2 signed: -1 < 1
      '{32'hFFFF_FFFF, 32'h0000_0001, 16'h1234, 1'b0, 1'b1, 3'd0, 1'b0, 4'b1000},
      // R2 unsigned: 0xFFFFFFFF > 1
      '{32'hFFFF_FFFF, 32'h0000_0001, 16'h1234, 1'b0, 1'b0, 3'd1, 1'b0, 4'b0100},
      // R6/R7 equal with SO
      '{32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b0, 1'b1, 3'd2, 1'b1, 4'b0011},
      // R4 imm 0xFFFF -> -1, 0 > -1
      '{32'h0000_0000, 32'h0000_0000, 16'hFFFF, 1'b1, 1'b1, 3'd3, 1'b0, 4'b0100},
      // R3 imm 0xFFFF -> 65535, 0 < 65535
      '{32'h0000_0000, 32'h0000_0000, 16'hFFFF, 1'b1, 1'b0, 3'd4, 1'b0, 4'b1000},
      // R3 zero-extended equal
      '{32'h0000_FFFF, 32'hDEAD_BEEF, 16'hFFFF, 1'b1, 1'b0, 3'd5, 1'b0, 4'b0010},
      // R4 sign-extended equal, SO set
      '{32'hFFFF_FFFF, 32'h0000_0000, 16'hFFFF, 1'b1, 1'b1, 3'd6, 1'b1, 4'b0011},
      // R2 most negative < most positive (signed), field 7
      '{32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 1'b0, 1'b1, 3'd7, 1'b0, 4'b1000},
      // R2 unsigned reverses, overwrite field 7
      '{32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 1'b0, 1'b0, 3'd7, 1'b0, 4'b0100},
      // R5 register path, immediate would say equal
      '{32'h0000_0007, 32'h0000_0003, 16'h0007, 1'b0, 1'b1, 3'd0, 1'b0, 4'b0100},
      // R4 imm 0x8000 -> -32768, 3 > it, SO set
      '{32'h0000_0003, 32'h0000_0000, 16'h8000, 1'b1, 1'b1, 3'd1, 1'b1, 4'b0101},
      // R3 imm 0x8000 -> 32768, 3 < it
      '{32'h0000_0003, 32'h0000_0000, 16'h8000, 1'b1, 1'b0, 3'd2, 1'b0, 4'b1000}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        valid_i;
   logic [31:0] opa_i, opb_i;
   logic [15:0] imm_i;
   logic        use_imm_i, signed_i, so_i;
   logic [2:0]  field_i;
   logic [31:0] cr_o;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] model;
   bit done = 0;

   always #10 clk = ~clk;

   intcmp_crf u_intcmp_crf (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (valid_i),
      .opa_i     (opa_i),
      .opb_i     (opb_i),
      .imm_i     (imm_i),
      .use_imm_i (use_imm_i),
      .signed_i  (signed_i),
      .field_i   (field_i),
      .so_i      (so_i),
      .cr_o      (cr_o)
   );

   function automatic logic [31:0] put_field(input logic [31:0] cr, input int idx,
                                             input logic [3:0] n);
      logic [31:0] r = cr;
      r[31 - idx*4 -: 4] = n;
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: cr_o=%08h expected %08h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic vld);
      opa_i = v.a; opb_i = v.b; imm_i = v.imm; use_imm_i = v.use_imm;
      signed_i = v.sgn; field_i = v.fld; so_i = v.so; valid_i = vld;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, cycles=%0d expected<=%0d", wd, 5000);
            finish_run();
         end
      end
   end

   initial begin
      vec_t idle;
      idle = '{32'h1111_1111, 32'h2222_2222, 16'h3333, 1'b0, 1'b1, 3'd0, 1'b1, 4'b0000};
      rst_n = 1'b0;
      drive(idle, 1'b0);
      model = '0;
      repeat (3) @(negedge clk);
      check("R1 reset value", cr_o, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 zero after release", cr_o, 32'h0);

      // Table walk: each vector one cycle, checked before and after the edge.
      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i], 1'b1);
         #1;
         check("R9 no early update", cr_o, model);
         model = put_field(model, int'(VECS[i].fld), VECS[i].expn);
         @(negedge clk);
         valid_i = 1'b0;
         check($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i), cr_o, model);
      end

      // R9: strobe low, inputs churning, register frozen.
      for (int j = 0; j < 4; j++) begin
         drive('{32'h0 + j, 32'h5 - j, 16'h8000 + 16'(j), 1'(j), 1'(j >> 1),
                 3'(j), 1'b1, 4'b0}, 1'b0);
         @(negedge clk);
         check("R9 idle hold", cr_o, model);
      end

      // R8: default index 0 targets bits 31:28 only.
      drive('{32'h0000_0002, 32'h0000_0009, 16'h0, 1'b0, 1'b0, 3'd0, 1'b0, 4'b1000}, 1'b1);
      model = put_field(model, 0, 4'b1000);
      @(negedge clk);
      valid_i = 1'b0;
      check("R8 field 0 is bits 31:28", cr_o, model);

      // R8: field 7 targets bits 3:0 only.
      drive('{32'h0000_0009, 32'h0000_0009, 16'h0, 1'b0, 1'b0, 3'd7, 1'b1, 4'b0011}, 1'b1);
      model = put_field(model, 7, 4'b0011);
      @(negedge clk);
      valid_i = 1'b0;
      check("R8 field 7 is bits 3:0", cr_o, model);

      // R1: mid-run reset clears everything.
      rst_n = 1'b0;
      @(negedge clk);
      model = '0;
      check("R1 mid-run reset", cr_o, model);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 stays clear", cr_o, model);

      finish_run();
   end

endmodule